// File: doc/BRIEF.md
# SM4 Four-Round Engine

This block advances an SM4 working state by four rounds per operation. A state of four 32-bit words and four 32-bit round keys are captured when `start_i` is accepted. One round is then computed per clock. Each round XORs three of the words with a key, passes the result through the byte-wise substitution, applies a linear mix and folds it into the remaining word. The window of four words then slides forward by one word.

A single datapath covers both uses of the round. With `mode_i` low it runs cipher rounds. With `mode_i` high it runs key-schedule rounds, which differ only in the linear mix. The `NUM_LANES` parameter sets the number of 128-bit lanes; the default of two gives the 256-bit form. Every lane uses only its own slice of the state and key buses, and all lanes share one sequencer.

The surrounding logic feeds round keys, gathers the outputs and runs any wider schedule. The engine only does the four-round step and a simple start/busy/done handshake.

Top module: `sm4x_unit`

## Requirements
- R1: With mode 0 (cipher), each new word is W0 ^ Lc(T(W1 ^ W2 ^ W3 ^ k)), where Lc(x) = x ^ rotl(x,2) ^ rotl(x,10) ^ rotl(x,18) ^ rotl(x,24).
- R2: With mode 1 (key schedule), the same round uses Lk(x) = x ^ rotl(x,13) ^ rotl(x,23) in place of Lc.
- R3: Word w of a lane sits at bits [32w+31:32w] of that lane's state, key and result slices. Round r uses key word r and the current window (W0..W3). It then shifts the window to (W1, W2, W3, new). The result holds the four new words, with word r being the one produced by round r.
- R4: T replaces each byte of its 32-bit input in place with the SM4 S-box value. Among others, the S-box maps 00→D6, 01→90, 02→E9, 03→FE, 04→CC, 05→E1 and FF→48.
- R5: `start_i` is accepted on a rising edge where `busy_o` is low. From the next cycle `busy_o` is high for exactly four cycles. `done_o` is then high for one cycle, in which `busy_o` is low and the result is final.
- R6: `start_i` while `busy_o` is high is ignored. It changes neither the running result nor the time at which `done_o` comes.
- R7: The mode is taken at acceptance. Changing `mode_i` during a run has no effect on that run.
- R8: Lane l (slice [128l+127:128l]) is computed from its own state and key slices only. Other lanes do not affect it.
- R9: After a clock edge with `rst` high, `busy_o` and `done_o` are low and `result_o` is zero.
- R10: While no operation is running and none is accepted, `result_o` keeps its last value, whatever the state, key and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a four-round operation |
| mode_i | input | 1 | 0 = cipher rounds, 1 = key-schedule rounds |
| state_i | input | 128*NUM_LANES | Input words, four per lane |
| key_i | input | 128*NUM_LANES | Round keys, four per lane |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is final |
| result_o | output | 128*NUM_LANES | The four new words of each lane |

## Verification
A wrong S-box entry or a wrong rotation corrupts the word made in the round where it strikes. Because that word feeds every later round, the error spreads through the rest of the lane's result. It shows at `done_o`, four cycles after acceptance. An error in the window shift or key shift shows as swapped or wrong words in the same final snapshot.

A miscounting sequencer shows at the ports in the cycle it happens, as a busy window that is too short or too long or a done pulse at the wrong time. A mode register that follows the pin instead of holding its captured value only shows when `mode_i` moves during a run, so the bench toggles it there on purpose.

// File: rtl/sm4x_pkg.sv
package sm4x_pkg;

    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int LANE_W = WORD_W * WORDS;
    localparam int BYTE_W = 8;
    localparam int BYTES  = WORD_W / BYTE_W;
    localparam int SBOX_N = 1 << BYTE_W;
    localparam int CNT_W  = $clog2(WORDS);
    localparam int RUN_W  = CNT_W + 2;

    // Field polynomial x^8+x^7+x^6+x^5+x^4+x^2+1 and affine offset
    localparam logic [BYTE_W-1:0] GF_RED = 8'hF5;
    localparam logic [BYTE_W-1:0] AFF_C  = 8'hD3;

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [WORDS-1:0][WORD_W-1:0]  block_t;
    typedef logic [BYTE_W-1:0]             byte_t;

    typedef enum logic {
        MODE_CIPHER = 1'b0,
        MODE_KEYEXP = 1'b1
    } mode_e;

    function automatic byte_t rotr8(byte_t x, int n);
        return byte_t'((x >> n) | (x << (BYTE_W - n)));
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = t[BYTE_W-1] ? (byte_t'(t << 1) ^ GF_RED) : byte_t'(t << 1);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse, with 0 mapping to 0
    function automatic byte_t gf_inv(byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int i = 0; i < BYTE_W - 1; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t aff_mix(byte_t x);
        return x ^ rotr8(x, 1) ^ rotr8(x, 2) ^ rotr8(x, 5) ^ rotr8(x, 7);
    endfunction

    function automatic byte_t sbox_byte(byte_t x);
        return aff_mix(gf_inv(aff_mix(x) ^ AFF_C)) ^ AFF_C;
    endfunction

    function automatic word_t rotl32(word_t x, int n);
        return word_t'((x << n) | (x >> (WORD_W - n)));
    endfunction

    function automatic word_t lin_cipher(word_t x);
        return x ^ rotl32(x, 2) ^ rotl32(x, 10) ^ rotl32(x, 18) ^ rotl32(x, 24);
    endfunction

    function automatic word_t lin_keyexp(word_t x);
        return x ^ rotl32(x, 13) ^ rotl32(x, 23);
    endfunction

endpackage

// File: rtl/sm4x_sbox.sv
module sm4x_sbox
    import sm4x_pkg::*;
(
    input  byte_t byte_i,
    output byte_t byte_o
);

    // Table filled at elaboration from the algebraic definition
    logic [SBOX_N-1:0][BYTE_W-1:0] rom;

    for (genvar g = 0; g < SBOX_N; g++) begin : g_rom
        localparam byte_t ENTRY = sbox_byte(byte_t'(g));
        assign rom[g] = ENTRY;
    end

    assign byte_o = rom[byte_i];

endmodule

// File: rtl/sm4x_round.sv
module sm4x_round
    import sm4x_pkg::*;
(
    input  block_t win_i,
    input  word_t  rk_i,
    input  mode_e  mode_i,
    output word_t  new_o
);

    word_t mix;
    word_t subst;
    word_t lin;

    assign mix = win_i[1] ^ win_i[2] ^ win_i[3] ^ rk_i;

    for (genvar b = 0; b < BYTES; b++) begin : g_tau
        sm4x_sbox u_sbox (
            .byte_i (mix[b*BYTE_W +: BYTE_W]),
            .byte_o (subst[b*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        if (mode_i == MODE_KEYEXP) lin = lin_keyexp(subst);
        else                       lin = lin_cipher(subst);
    end

    assign new_o = win_i[0] ^ lin;

endmodule

// File: rtl/sm4x_ctrl.sv
module sm4x_ctrl
    import sm4x_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  mode_e mode_i,
    output logic  load_o,
    output logic  step_o,
    output mode_e mode_o,
    output logic  busy_o,
    output logic  done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    logic [CNT_W-1:0] cnt;
    logic             busy_q;
    logic             done_q;
    mode_e            mode_q;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt    <= '0;
            mode_q <= MODE_CIPHER;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt    <= '0;
                mode_q <= mode_i;
            end else if (busy_q) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign mode_o = mode_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/sm4x_lane.sv
module sm4x_lane
    import sm4x_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  logic   step_i,
    input  mode_e  mode_i,
    input  block_t state_i,
    input  block_t key_i,
    output block_t result_o
);

    block_t win;
    block_t keys;
    word_t  fresh;

    sm4x_round u_round (
        .win_i  (win),
        .rk_i   (keys[0]),
        .mode_i (mode_i),
        .new_o  (fresh)
    );

    // Window slides by one word per round; after the last round it
    // holds exactly the four produced words in order.
    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            keys <= '0;
        end else if (load_i) begin
            win  <= state_i;
            keys <= key_i;
        end else if (step_i) begin
            win  <= {fresh, win[WORDS-1:1]};
            keys <= {word_t'(0), keys[WORDS-1:1]};
        end
    end

    assign result_o = win;

endmodule

// File: rtl/sm4x_unit.sv
module sm4x_unit
    import sm4x_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        mode_i,
    input  logic [NUM_LANES*LANE_W-1:0] state_i,
    input  logic [NUM_LANES*LANE_W-1:0] key_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [NUM_LANES*LANE_W-1:0] result_o
);

    logic  load;
    logic  step;
    mode_e mode_run;

    sm4x_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (mode_e'(mode_i)),
        .load_o  (load),
        .step_o  (step),
        .mode_o  (mode_run),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        block_t lane_res;
        sm4x_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .load_i   (load),
            .step_i   (step),
            .mode_i   (mode_run),
            .state_i  (state_i[l*LANE_W +: LANE_W]),
            .key_i    (key_i[l*LANE_W +: LANE_W]),
            .result_o (lane_res)
        );
        assign result_o[l*LANE_W +: LANE_W] = lane_res;
    end

endmodule

// File: rtl/sm4x_unit_chk.sv
module sm4x_unit_chk
    import sm4x_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        start_i,
    input logic                        busy_o,
    input logic                        done_o,
    input logic [NUM_LANES*LANE_W-1:0] result_o
);

    logic [RUN_W-1:0] run_len;
    logic             rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                      run_len <= '0;
        else if (start_i && !busy_o)  run_len <= '0;
        else if (busy_o)              run_len <= run_len + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R9: assert (!busy_o && !done_o && result_o == '0);
        end
    end

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_len_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_len == RUN_W'(WORDS)));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_len < RUN_W'(WORDS)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(result_o));

endmodule

bind sm4x_unit sm4x_unit_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sm4x_unit_tb.sv
module sm4x_unit_tb;

    localparam int NL = 2;
    localparam int LW = 128;
    localparam int NV = 6;

    localparam logic [LW-1:0] TV_ST [NV] = '{
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h3C1E_0F87_C3E1_F078_1234_5678_9ABC_DEF0,
        128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_5EED_1234,
        128'h8000_0001_7FFF_FFFE_0000_FFFF_FFFF_0000
    };
    localparam logic [LW-1:0] TV_KY [NV] = '{
        128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'h1357_9BDF_2468_ACE0_FDB9_7531_ECA8_6420,
        128'hA5A5_5A5A_C3C3_3C3C_0000_FFFF_1111_EEEE,
        128'h7766_5544_3322_1100_FFEE_DDCC_BBAA_9988,
        128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10
    };
    localparam logic [NV-1:0] TV_MD = 6'b011010;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               mode = 1'b0;
    logic [NL*LW-1:0]   st = '0;
    logic [NL*LW-1:0]   ky = '0;
    logic               busy;
    logic               done;
    logic [NL*LW-1:0]   res;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] inv_t [256];

    always #5 clk = ~clk;

    sm4x_unit #(.NUM_LANES(NL)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .mode_i   (mode),
        .state_i  (st),
        .key_i    (ky),
        .busy_o   (busy),
        .done_o   (done),
        .result_o (res)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h01F5 << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_aff(logic [7:0] x);
        logic [7:0] y;
        for (int i = 0; i < 8; i++)
            y[i] = x[i] ^ x[(i+1)%8] ^ x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        return y;
    endfunction

    function automatic logic [7:0] m_sbox(logic [7:0] x);
        return m_aff(inv_t[m_aff(x) ^ 8'hD3]) ^ 8'hD3;
    endfunction

    function automatic logic [31:0] m_rotl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] m_lin(logic [31:0] x, logic m);
        if (m) return x ^ m_rotl(x, 13) ^ m_rotl(x, 23);
        return x ^ m_rotl(x, 2) ^ m_rotl(x, 10) ^ m_rotl(x, 18) ^ m_rotl(x, 24);
    endfunction

    function automatic logic [31:0] m_tau(logic [31:0] x);
        return {m_sbox(x[31:24]), m_sbox(x[23:16]), m_sbox(x[15:8]), m_sbox(x[7:0])};
    endfunction

    function automatic logic [LW-1:0] m_lane(logic [LW-1:0] s, logic [LW-1:0] k, logic m);
        logic [31:0] w [8];
        for (int i = 0; i < 4; i++) w[i] = s[32*i +: 32];
        for (int r = 0; r < 4; r++)
            w[r+4] = w[r] ^ m_lin(m_tau(w[r+1] ^ w[r+2] ^ w[r+3] ^ k[32*r +: 32]), m);
        return {w[7], w[6], w[5], w[4]};
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Accept on the next edge, then count edges until done is seen
    task automatic run_op(input logic [NL*LW-1:0] s, input logic [NL*LW-1:0] k,
                          input logic m, output int lat);
        @(negedge clk);
        st = s; ky = k; mode = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!done && lat < 10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R5 act=hung exp=finished");
        finish_up();
    end

    initial begin
        int lat;
        logic [LW-1:0] lo_keep;

        for (int a = 0; a < 256; a++) begin
            inv_t[a] = 8'h00;
            for (int b = 1; b < 256; b++)
                if (m_mul(8'(a), 8'(b)) == 8'h01) inv_t[a] = 8'(b);
        end

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 busy/done after reset", LW'({busy, done}), '0);
        chk("R9 result after reset lo", res[LW-1:0], '0);
        chk("R9 result after reset hi", res[2*LW-1:LW], '0);
        rst = 1'b0;

        // R4: S-box points through word 0, other words zero
        run_op({{LW{1'b0}}, {LW{1'b0}}}, {{LW{1'b0}}, 96'h0, 32'h0001_0203}, 1'b0, lat);
        chk("R4 R1 sbox 00..03", LW'(res[31:0]), LW'(m_lin(32'hD690_E9FE, 1'b0)));
        run_op({{LW{1'b0}}, {LW{1'b0}}}, {{LW{1'b0}}, 96'h0, 32'h0405_FF00}, 1'b1, lat);
        chk("R4 R2 sbox 04,05,FF,00", LW'(res[31:0]), LW'(m_lin(32'hCCE1_48D6, 1'b1)));

        // R1 R2 R3 R8 R5: vector table, both lanes differ
        for (int v = 0; v < NV; v++) begin
            logic [LW-1:0] s_hi, k_hi;
            s_hi = {TV_ST[v][63:0], TV_ST[v][127:64]} ^ {4{32'h5A5A_C3C3}};
            k_hi = ~TV_KY[v];
            run_op({s_hi, TV_ST[v]}, {k_hi, TV_KY[v]}, TV_MD[v], lat);
            chk(TV_MD[v] ? "R2 R3 lane0" : "R1 R3 lane0", res[LW-1:0],
                m_lane(TV_ST[v], TV_KY[v], TV_MD[v]));
            chk(TV_MD[v] ? "R2 R8 lane1" : "R1 R8 lane1", res[2*LW-1:LW],
                m_lane(s_hi, k_hi, TV_MD[v]));
            chk("R5 latency", LW'(lat), LW'(4));
        end

        // R5: done lasts one cycle
        @(posedge clk);
        @(negedge clk);
        chk("R5 done single cycle", LW'({busy, done}), '0);

        // R8: change only lane 1, lane 0 must repeat
        run_op({TV_ST[2], TV_ST[0]}, {TV_KY[2], TV_KY[0]}, 1'b0, lat);
        lo_keep = res[LW-1:0];
        run_op({TV_ST[4], TV_ST[0]}, {TV_KY[5], TV_KY[0]}, 1'b0, lat);
        chk("R8 lane0 unaffected", res[LW-1:0], lo_keep);

        // R6 R7: start and mode toggled during a run
        @(negedge clk);
        st = {TV_ST[3], TV_ST[4]}; ky = {TV_KY[3], TV_KY[4]}; mode = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        st = {TV_ST[1], TV_ST[0]}; ky = {TV_KY[1], TV_KY[0]}; mode = 1'b0;
        lat = 0;
        @(posedge clk); lat++;
        @(negedge clk);
        @(posedge clk); lat++;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 10) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        chk("R6 latency with start while busy", LW'(lat), LW'(4));
        chk("R6 R7 lane0 result", res[LW-1:0], m_lane(TV_ST[4], TV_KY[4], 1'b1));
        chk("R7 lane1 result", res[2*LW-1:LW], m_lane(TV_ST[3], TV_KY[3], 1'b1));

        // R10: result holds while idle despite input changes
        lo_keep = res[LW-1:0];
        st = ~st; ky = ~ky; mode = ~mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 hold lane0", res[LW-1:0], lo_keep);
        chk("R10 idle flags", LW'({busy, done}), '0);

        finish_up();
    end

endmodule